// File: doc/BRIEF.md
# Backplane Bus Ownership Controller

This block lives on a processor card that shares a multi-master backplane with other cards. It decides when the card asks the backplane arbiter for the bus and when it gives the bus back. It then gates the card's isolating buffers so the processor only drives the backplane while the card owns the bus. Ownership can be gained in two ways. In the transparent way, an address decoder sees a processor access that falls inside the external window and raises a request without any software involvement. In the held way, software sets a lock bit so the bus stays owned across a long block transfer.

The two ways can be combined. After a transparent acquisition the card keeps the bus when the access is done. It gives the bus up when the arbiter raises the clear line, or when software drops the lock bit. While the lock bit is set, a clear request is ignored. A processor access that does not get the bus, or does not get a data acknowledge, within a programmable number of cycles ends with a bus error. Software can read an ownership status bit. An interrupt pulse marks a software-requested gain. The card requests on one selectable priority level and accepts a grant only on the grant line of that level.

Top module: `bm_request_ctl`

## Requirements
- R1: A processor access (`cpu_req` high) whose address satisfies `(cpu_addr & WIN_MASK) == WIN_BASE` makes the idle controller raise its request on the next clock edge. Accesses outside the window never raise a request.
- R2: Out of reset nothing is requested or owned. A grant on the selected level while requesting makes the controller owner on the next edge. At that point `bus_busy`, `buf_en` and `own_status` go high and `bus_req` returns to all zeros.
- R3: With `sw_lock` high, the idle controller requests the bus with no processor access pending. Once it owns the bus, it keeps ownership while `sw_lock` stays high, even if `bus_clear` is asserted.
- R4: After a transparent access completes, ownership is kept. With `sw_lock` low, an asserted `bus_clear` releases the bus on the next edge, provided no external access is in progress.
- R5: Clearing `sw_lock` releases the bus without any `bus_clear`. If an external access is in progress, the release waits until that access has ended.
- R6: On release, `bus_busy`, `buf_en` and `own_status` fall on the same clock edge, and `bus_req` stays all zeros.
- R7: While the bus is owned, a pending window access drives `bus_strobe` high. A `bus_dtack` seen at an edge gives a one-cycle `cpu_ack` on that edge.
- R8: If a window access is pending for `sw_timeout` edges without completing, `cpu_berr` pulses for one cycle on the `sw_timeout`-th edge. If the bus was never obtained and `sw_lock` is low, the request is then withdrawn.
- R9: A data-acknowledge timeout while the bus is owned also gives `cpu_berr`, and ownership is kept.
- R10: `own_irq` pulses high for exactly one cycle when ownership is gained while `sw_lock` is high. It stays low for a transparent gain.
- R11: `sw_level` (0 to 3) selects which single bit of `bus_req` is driven: bit n for level n. Grants on any other line are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access pending, held until ack or error |
| cpu_addr | input | ADDR_W | Processor access address |
| cpu_ack | output | 1 | One-cycle completion of an external access |
| cpu_berr | output | 1 | One-cycle bus error ending the access |
| sw_lock | input | 1 | Software hold bit |
| sw_level | input | 2 | Request priority level |
| sw_timeout | input | TMO_W | Access timeout in cycles |
| own_status | output | 1 | Ownership status bit for software polling |
| own_irq | output | 1 | Pulse on gain after a software request |
| bus_req | output | 4 | Request lines, one per level |
| bus_grant | input | 4 | Grant lines, one per level |
| bus_busy | output | 1 | Busy indication while owner |
| bus_clear | input | 1 | Arbiter request to give up the bus |
| bus_strobe | output | 1 | Access strobe on the backplane |
| bus_dtack | input | 1 | Data acknowledge from the backplane |
| buf_en | output | 1 | Isolating buffer enable |

## Verification
The assertions check several rules on every cycle. At most one request line is active. Acknowledge and error are never high together. The interrupt never lasts two cycles. The buffers only open after a grant on the selected line. Ownership never drops while the lock bit is held. The bench scenarios cover the ordering-dependent behaviour: the exact cycle in which a timeout error appears, that the bus is kept after a transparent access until clear arrives, that a release waits for an access in flight, and that a grant on a foreign level is refused.

// File: rtl/bm_pkg.sv
// Shared types for the bus ownership controller.
// Assumes four arbitration levels on the backplane.
package bm_pkg;
    localparam int unsigned LEVELS = 4;
    localparam int unsigned LVL_W  = $clog2(LEVELS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_HELD = 2'd2
    } own_state_t;
endpackage

// File: rtl/bm_window_decode.sv
// Address window decoder: flags processor addresses that belong to the
// backplane window. Assumes the window is a masked compare.
module bm_window_decode #(
    parameter int unsigned ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = 24'hC0_0000,
    parameter logic [ADDR_W-1:0] WIN_MASK = 24'hF0_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // Masked compare against the window base.
    always_comb begin
        hit = ((addr & WIN_MASK) == WIN_BASE);
    end
endmodule

// File: rtl/bm_cycle_timer.sv
// Access sequencer and timeout: drives the strobe while the bus is owned,
// turns a data acknowledge into a processor ack, and raises a bus error when
// an access stays pending for the programmed number of cycles.
// Assumes the processor holds its request until ack or error.
module bm_cycle_timer #(
    parameter int unsigned TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend,
    input  logic             owned,
    input  logic             dtack,
    input  logic [TMO_W-1:0] timeout,
    output logic             strobe,
    output logic             ack_q,
    output logic             berr_q
);
    logic [TMO_W-1:0] wait_cnt;
    logic [TMO_W:0]   wait_nxt;
    logic             done_now;

    // Strobe the backplane only while owning with an access pending.
    always_comb begin
        strobe   = owned && pend;
        done_now = strobe && dtack;
        wait_nxt = {1'b0, wait_cnt} + 1'b1;
    end

    // Count waiting cycles and issue ack or error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            ack_q    <= 1'b0;
            berr_q   <= 1'b0;
        end else begin
            ack_q  <= done_now;
            berr_q <= pend && !done_now && (wait_nxt >= {1'b0, timeout});
            if (!pend || done_now) begin
                wait_cnt <= '0;
            end else if (wait_nxt[TMO_W] == 1'b0) begin
                wait_cnt <= wait_nxt[TMO_W-1:0];
            end
        end
    end

    // R7: an ack only ever follows a strobe with acknowledge.
    a_r7_ack_after_dtack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> $past(strobe && dtack));
    // R8: error and ack are exclusive.
    a_r8_ack_berr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_q && berr_q));
endmodule

// File: rtl/bm_owner_fsm.sv
// Ownership state machine: requests the bus on a window access or a held
// lock bit, takes the grant of its own level only, keeps the bus until the
// arbiter clears or software releases, and pulses an interrupt on a
// software-requested gain. Assumes sw_level is static while requesting.
module bm_owner_fsm
    import bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend,
    input  logic              strobe,
    input  logic              lock,
    input  logic [LVL_W-1:0]  level,
    input  logic [LEVELS-1:0] grant,
    input  logic              clear,
    output logic [LEVELS-1:0] req,
    output logic              owned,
    output logic              irq_q
);
    own_state_t state_q, state_d;
    logic lock_q;
    logic rel_pend_q;
    logic my_grant;
    logic lock_fell;
    logic release_go;

    // Pick the grant line of the configured level.
    always_comb begin
        my_grant   = grant[level];
        lock_fell  = lock_q && !lock;
        owned      = (state_q == ST_HELD);
        release_go = owned && !lock && !strobe &&
                     (clear || rel_pend_q || lock_fell);
    end

    // Drive one request line per level from the request state.
    for (genvar g = 0; g < LEVELS; g++) begin : g_req
        assign req[g] = (state_q == ST_REQ) && (level == LVL_W'(g));
    end

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pend || lock) state_d = ST_REQ;
            ST_REQ: begin
                if (my_grant)            state_d = ST_HELD;
                else if (!pend && !lock) state_d = ST_IDLE;
            end
            ST_HELD: if (release_go) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, lock history, pending release and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lock_q     <= 1'b0;
            rel_pend_q <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            state_q    <= state_d;
            lock_q     <= lock;
            rel_pend_q <= (state_d == ST_HELD) && (rel_pend_q || lock_fell);
            irq_q      <= (state_q == ST_REQ) && (state_d == ST_HELD) && lock;
        end
    end

    // R3: the lock bit keeps ownership regardless of the clear line.
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && lock) |=> owned);
    // R11: at most one request line is active.
    a_r11_one_level: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req));
    // R10: the interrupt is a single-cycle pulse.
    a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
endmodule

// File: rtl/bm_request_ctl.sv
// Top of the backplane bus ownership controller. Ties the window decoder,
// the ownership state machine and the access timer together and exposes
// the card-side and backplane-side signals. All backplane lines are
// active high here; pad inversion is outside this block.
module bm_request_ctl
    import bm_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = 24'hC0_0000,
    parameter logic [ADDR_W-1:0] WIN_MASK = 24'hF0_0000,
    parameter int unsigned TMO_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ack,
    output logic              cpu_berr,
    input  logic              sw_lock,
    input  logic [1:0]        sw_level,
    input  logic [TMO_W-1:0]  sw_timeout,
    output logic              own_status,
    output logic              own_irq,
    output logic [3:0]        bus_req,
    input  logic [3:0]        bus_grant,
    output logic              bus_busy,
    input  logic              bus_clear,
    output logic              bus_strobe,
    input  logic              bus_dtack,
    output logic              buf_en
);
    logic win_hit;
    logic pend;
    logic owned;
    logic strobe;
    logic ack_q;
    logic berr_q;

    bm_window_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_MASK (WIN_MASK)
    ) u_dec (
        .addr (cpu_addr),
        .hit  (win_hit)
    );

    // An external access is pending until its ack or error pulse.
    always_comb begin
        pend = cpu_req && win_hit && !ack_q && !berr_q;
    end

    bm_owner_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend),
        .strobe (strobe),
        .lock   (sw_lock),
        .level  (sw_level),
        .grant  (bus_grant),
        .clear  (bus_clear),
        .req    (bus_req),
        .owned  (owned),
        .irq_q  (own_irq)
    );

    bm_cycle_timer #(
        .TMO_W (TMO_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .owned   (owned),
        .dtack   (bus_dtack),
        .timeout (sw_timeout),
        .strobe  (strobe),
        .ack_q   (ack_q),
        .berr_q  (berr_q)
    );

    // Output mapping: busy, buffers and status all follow ownership.
    always_comb begin
        cpu_ack    = ack_q;
        cpu_berr   = berr_q;
        bus_busy   = owned;
        buf_en     = owned;
        own_status = owned;
        bus_strobe = strobe;
    end

    // R2: buffers open only after a grant on the selected line.
    a_r2_buf_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_en) |-> $past(bus_grant[sw_level]));
    // R5: ownership is never dropped while the lock bit is held.
    a_r5_no_drop_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_busy) |-> !$past(sw_lock));
    // R1: outside-window accesses alone never start a request from idle.
    a_r1_local_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!owned && bus_req == 4'b0 && !sw_lock && !(cpu_req && win_hit))
        |=> bus_req == 4'b0);
    // R7: the strobe is only driven while the buffers are open.
    a_r7_strobe_owned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |-> buf_en);
endmodule

// File: tb/bm_request_ctl_test.sv
module bm_request_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_ack, cpu_berr;
    logic        sw_lock = 1'b0;
    logic [1:0]  sw_level = 2'd0;
    logic [7:0]  sw_timeout = 8'd20;
    logic        own_status, own_irq;
    logic [3:0]  bus_req;
    logic [3:0]  bus_grant = 4'b0;
    logic        bus_busy;
    logic        bus_clear = 1'b0;
    logic        bus_strobe;
    logic        bus_dtack = 1'b0;
    logic        buf_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bm_request_ctl uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_ack(cpu_ack), .cpu_berr(cpu_berr), .sw_lock(sw_lock),
        .sw_level(sw_level), .sw_timeout(sw_timeout),
        .own_status(own_status), .own_irq(own_irq), .bus_req(bus_req),
        .bus_grant(bus_grant), .bus_busy(bus_busy), .bus_clear(bus_clear),
        .bus_strobe(bus_strobe), .bus_dtack(bus_dtack), .buf_en(buf_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_owned(input string tag, input int exp);
        chk({tag, " busy"}, int'(bus_busy), exp);
        chk({tag, " buf_en"}, int'(buf_en), exp);
        chk({tag, " status"}, int'(own_status), exp);
    endtask

    task automatic t_reset();
        chk("R2 reset req", int'(bus_req), 0);
        chk_owned("R2 reset", 0);
        chk("R2 reset ack", int'(cpu_ack), 0);
        chk("R2 reset berr", int'(cpu_berr), 0);
    endtask

    task automatic t_local();
        cpu_addr = 24'h12_3456;
        cpu_req  = 1'b1;
        repeat (3) tick();
        chk("R1 local no request", int'(bus_req), 0);
        cpu_req = 1'b0;
        tick();
    endtask

    task automatic t_transparent();
        sw_level   = 2'd1;
        sw_timeout = 8'd20;
        cpu_addr   = 24'hC0_1000;
        cpu_req    = 1'b1;
        tick();
        chk("R1 window request", int'(bus_req), 2);
        bus_grant = 4'b0001;
        tick();
        chk("R11 foreign grant ignored", int'(bus_busy), 0);
        bus_grant = 4'b0010;
        tick();
        chk_owned("R2 gained", 1);
        chk("R2 req dropped", int'(bus_req), 0);
        chk("R10 no irq transparent", int'(own_irq), 0);
        bus_grant = 4'b0;
        chk("R7 strobe", int'(bus_strobe), 1);
        bus_dtack = 1'b1;
        tick();
        chk("R7 ack", int'(cpu_ack), 1);
        cpu_req = 1'b0;
        bus_dtack = 1'b0;
        repeat (3) tick();
        chk("R4 ack one cycle", int'(cpu_ack), 0);
        chk("R4 kept after access", int'(bus_busy), 1);
        bus_clear = 1'b1;
        tick();
        chk_owned("R6 released on clear", 0);
        chk("R6 req low", int'(bus_req), 0);
        bus_clear = 1'b0;
        tick();
    endtask

    task automatic t_lock();
        sw_level = 2'd3;
        sw_lock  = 1'b1;
        tick();
        chk("R3 lock request", int'(bus_req), 8);
        bus_grant = 4'b1000;
        tick();
        chk("R3 lock owned", int'(own_status), 1);
        chk("R10 irq high", int'(own_irq), 1);
        bus_grant = 4'b0;
        tick();
        chk("R10 irq single", int'(own_irq), 0);
        bus_clear = 1'b1;
        repeat (3) tick();
        chk("R3 clear ignored", int'(bus_busy), 1);
        bus_clear = 1'b0;
        cpu_addr  = 24'hC2_0000;
        cpu_req   = 1'b1;
        tick();
        chk("R5 locked strobe", int'(bus_strobe), 1);
        sw_lock = 1'b0;
        tick();
        chk("R5 waits for access", int'(bus_busy), 1);
        bus_dtack = 1'b1;
        tick();
        chk("R7 locked ack", int'(cpu_ack), 1);
        chk("R5 still owned at ack", int'(bus_busy), 1);
        cpu_req   = 1'b0;
        bus_dtack = 1'b0;
        tick();
        chk_owned("R5 released", 0);
        chk("R6 req low after unlock", int'(bus_req), 0);
        tick();
    endtask

    task automatic t_grant_timeout();
        sw_level   = 2'd0;
        sw_timeout = 8'd6;
        cpu_addr   = 24'hCF_FFFE;
        cpu_req    = 1'b1;
        repeat (5) tick();
        chk("R8 no early berr", int'(cpu_berr), 0);
        tick();
        chk("R8 berr on time", int'(cpu_berr), 1);
        cpu_req = 1'b0;
        tick();
        chk("R8 berr single", int'(cpu_berr), 0);
        chk("R8 request withdrawn", int'(bus_req), 0);
        chk("R8 not owned", int'(bus_busy), 0);
        tick();
    endtask

    task automatic t_dtack_timeout();
        sw_level   = 2'd2;
        sw_timeout = 8'd5;
        cpu_addr   = 24'hC0_0040;
        cpu_req    = 1'b1;
        tick();
        chk("R11 level two", int'(bus_req), 4);
        bus_grant = 4'b0100;
        tick();
        bus_grant = 4'b0;
        chk("R9 owned", int'(bus_busy), 1);
        repeat (2) tick();
        chk("R9 no early berr", int'(cpu_berr), 0);
        tick();
        chk("R9 berr", int'(cpu_berr), 1);
        chk("R9 kept at berr", int'(bus_busy), 1);
        cpu_req = 1'b0;
        repeat (2) tick();
        chk("R9 kept after berr", int'(bus_busy), 1);
        bus_clear = 1'b1;
        tick();
        chk("R4 released", int'(bus_busy), 0);
        bus_clear = 1'b0;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_local();
        t_transparent();
        t_lock();
        t_grant_timeout();
        t_dtack_timeout();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule